// File: doc/BRIEF.md
# Single-Wire Configuration Register Slave

This block is the device end of a one-wire, open-drain programming link. A 14-bit mode word reaches the configuration register over this link. The shared line is seen as a level input. The block can pull it low through a drive-low output, and an external pull-up returns it high. A host starts a transfer by holding the line low and then releasing it. The block measures that start pulse. If the pulse is accepted, the block takes over the timing of the line for the rest of the transfer.

For each of the 14 bits, the block drives a short synchronization pulse. It then waits a gap and opens a sampling window. The host marks a 0 by pulling the line low inside the window; a bit the host leaves alone reads as 1. After the last bit comes an equivalence window. In it, the block answers with an acknowledge pulse only when the new word equals the stored one, so a host can program the same word twice to confirm a clean transfer. At the end of that window the word is written to the register and a done strobe fires. An off command is raised when the first received bit is 1.

A reset marker flag records that the device has been reset. While the flag is set, short start pulses are refused. A long start pulse always begins a transfer and clears the flag. Every delay is a parameter counted in system clocks.

Top module: `cfgw_slave`

## Requirements
- R1: After reset, `line_drive_low_o` and `fe_disable_o` are 0, `done_o` and `off_cmd_o` are 0, `cfg_word_o` is all ones (14'h3FFF), and `marker_o` is 1.
- R2: A low pulse of T1_MIN to SHORT_MAX cycles, counted inclusively, starts a transfer when `marker_o` is 0. The same pulse is ignored when `marker_o` is 1, and the marker stays 1.
- R3: A low pulse of LONG_MIN cycles or more always starts a transfer and clears `marker_o` to 0.
- R4: A low pulse shorter than T1_MIN is ignored: no transfer starts and `cfg_word_o` is unchanged. So is a pulse longer than SHORT_MAX and shorter than LONG_MIN.
- R5: Each accepted transfer drives exactly 14 synchronization pulses on the line, and each is T3 cycles long. The first comes T2 cycles after the release is detected. The pulses are T6 cycles apart.
- R6: The first received bit lands in `cfg_word_o[0]` and the 14th in bit 13. A bit is 0 when the synchronized line is low for at least ceil(T7/2) cycles of its T5-cycle window, which opens T4 cycles after its sync pulse ends. Otherwise the bit is 1.
- R7: After bit 14, a T9-cycle equivalence window follows. The block drives a single T8-cycle low pulse at the start of that window only if the received word equals the word stored before the transfer.
- R8: `cfg_word_o` takes the received word at the end of the equivalence window, in the same cycle as a one-cycle `done_o` pulse. It changes at no other time.
- R9: `off_cmd_o` pulses together with `done_o` exactly when bit 0 of the received word is 1.
- R10: `fe_disable_o` is 1 from the cycle after a start is accepted until the equivalence window ends. The block drives the line only while `fe_disable_o` is 1.
- R11: A high `rm_set_i` sets `marker_o` to 1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Level of the shared data line |
| rm_set_i | input | 1 | Reset event; sets the reset marker |
| line_drive_low_o | output | 1 | Pulls the shared line low when 1 |
| fe_disable_o | output | 1 | Front-end disable, high during a transfer |
| marker_o | output | 1 | Reset marker flag |
| cfg_word_o | output | 14 | Stored configuration word |
| done_o | output | 1 | One-cycle strobe when a word is committed |
| off_cmd_o | output | 1 | One-cycle off command, with `done_o` |

## Verification
A wrong frame counter or bit index shows up at once as a sync pulse of the wrong width or the wrong number of pulses per transfer. It also shows up as a word that comes out shifted or with a wrong bit when `done_o` fires, about 240 cycles after the start pulse in the small bench configuration. A bad start classification or marker update is seen within one start pulse: `fe_disable_o` rises when it should not, or stays low when it should rise, and `marker_o` holds the wrong value. A stale comparison is seen when a word is sent twice: the acknowledge pulse is missing or appears where it should not.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int WORD_W = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SYNC,
        ST_GAP,
        ST_WIN,
        ST_TAIL,
        ST_EQ
    } seq_state_t;

    typedef enum logic [1:0] {
        START_NONE,
        START_SHORT,
        START_LONG
    } start_kind_t;

    typedef struct packed {
        logic              strobe;
        logic [WORD_W-1:0] word;
    } commit_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Decide what a completed low pulse of len cycles means.
    function automatic start_kind_t classify_start(
        input int unsigned len,
        input int unsigned tmin,
        input int unsigned smax,
        input int unsigned lmin
    );
        if (len >= lmin)
            return START_LONG;
        else if (len >= tmin && len <= smax)
            return START_SHORT;
        else
            return START_NONE;
    endfunction

endpackage

// File: rtl/cfgw_sync.sv
module cfgw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfgw_start_det.sv
module cfgw_start_det
    import cfgw_pkg::*;
#(
    parameter int T1_MIN    = 16,
    parameter int SHORT_MAX = 1535,
    parameter int LONG_MIN  = 5632
) (
    input  logic clk,
    input  logic rst,
    input  logic line_s_i,
    input  logic busy_i,
    input  logic marker_i,
    output logic start_o,
    output logic clr_marker_o
);
    localparam int CW = $clog2(LONG_MIN + 1);
    localparam logic [CW-1:0] SAT = CW'(LONG_MIN);

    logic [CW-1:0] low_cnt;
    logic          prev_s;
    start_kind_t   kind;
    logic          release_seen;

    always_comb begin
        kind = classify_start(int'(low_cnt), T1_MIN, SHORT_MAX, LONG_MIN);
    end

    assign release_seen = line_s_i && !prev_s && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt      <= '0;
            prev_s       <= 1'b1;
            start_o      <= 1'b0;
            clr_marker_o <= 1'b0;
        end else begin
            prev_s       <= line_s_i;
            start_o      <= 1'b0;
            clr_marker_o <= 1'b0;
            if (busy_i) begin
                low_cnt <= '0;
            end else if (!line_s_i) begin
                if (low_cnt != SAT)
                    low_cnt <= low_cnt + 1'b1;
            end else begin
                if (release_seen) begin
                    start_o      <= (kind == START_LONG) ||
                                    (kind == START_SHORT && !marker_i);
                    clr_marker_o <= (kind == START_LONG);
                end
                low_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/cfgw_frame_seq.sv
module cfgw_frame_seq
    import cfgw_pkg::*;
#(
    parameter int T2 = 64,
    parameter int T3 = 32,
    parameter int T4 = 32,
    parameter int T5 = 128,
    parameter int T6 = 256,
    parameter int T7 = 64,
    parameter int T8 = 32,
    parameter int T9 = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              line_s_i,
    input  logic              match_i,
    output logic              drive_o,
    output logic              busy_o,
    output commit_t           commit_o
);
    localparam int TAIL  = T6 - T3 - T4 - T5;
    localparam int HALF  = (T7 + 1) / 2;
    localparam int MAXT  = max_of(max_of(max_of(T2, T3), max_of(T4, T5)),
                                  max_of(max_of(TAIL, T9), T8));
    localparam int CW    = $clog2(MAXT + 1) + 1;
    localparam int BW    = $clog2(WORD_W);

    seq_state_t        state;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     low_cnt;
    logic [CW-1:0]     low_next;
    logic [CW-1:0]     eq_elapsed;
    logic [BW-1:0]     bit_idx;
    logic [WORD_W-1:0] rx_word;

    assign low_next   = low_cnt + (line_s_i ? 1'b0 : 1'b1);
    assign eq_elapsed = CW'(T9 - 1) - cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            low_cnt <= '0;
            bit_idx <= '0;
            rx_word <= '1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state   <= ST_DELAY;
                        cnt     <= CW'(T2 - 1);
                        bit_idx <= '0;
                    end
                end
                ST_DELAY: begin
                    if (cnt == '0) begin
                        state <= ST_SYNC;
                        cnt   <= CW'(T3 - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (cnt == '0) begin
                        state <= ST_GAP;
                        cnt   <= CW'(T4 - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) begin
                        state   <= ST_WIN;
                        cnt     <= CW'(T5 - 1);
                        low_cnt <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WIN: begin
                    low_cnt <= low_next;
                    if (cnt == '0) begin
                        rx_word[bit_idx] <= (low_next < CW'(HALF));
                        state <= ST_TAIL;
                        cnt   <= CW'(TAIL - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt == '0) begin
                        if (bit_idx == BW'(WORD_W - 1)) begin
                            state <= ST_EQ;
                            cnt   <= CW'(T9 - 1);
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= ST_SYNC;
                            cnt     <= CW'(T3 - 1);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_EQ: begin
                    if (cnt == '0)
                        state <= ST_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o          = (state != ST_IDLE);
    assign drive_o         = (state == ST_SYNC) ||
                             (state == ST_EQ && match_i && eq_elapsed < CW'(T8));
    assign commit_o.strobe = (state == ST_EQ) && (cnt == '0);
    assign commit_o.word   = rx_word;
endmodule

// File: rtl/cfgw_slave.sv
module cfgw_slave
    import cfgw_pkg::*;
#(
    parameter int T1_MIN    = 16,
    parameter int SHORT_MAX = 1535,
    parameter int LONG_MIN  = 5632,
    parameter int T2        = 64,
    parameter int T3        = 32,
    parameter int T4        = 32,
    parameter int T5        = 128,
    parameter int T6        = 256,
    parameter int T7        = 64,
    parameter int T8        = 32,
    parameter int T9        = 128,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic              rm_set_i,
    output logic              line_drive_low_o,
    output logic              fe_disable_o,
    output logic              marker_o,
    output logic [WORD_W-1:0] cfg_word_o,
    output logic              done_o,
    output logic              off_cmd_o
);
    logic    line_s;
    logic    start;
    logic    clr_marker;
    logic    busy;
    logic    match;
    commit_t commit;

    cfgw_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (line_i),
        .q_o (line_s)
    );

    cfgw_start_det #(
        .T1_MIN    (T1_MIN),
        .SHORT_MAX (SHORT_MAX),
        .LONG_MIN  (LONG_MIN)
    ) u_start (
        .clk          (clk),
        .rst          (rst),
        .line_s_i     (line_s),
        .busy_i       (busy),
        .marker_i     (marker_o),
        .start_o      (start),
        .clr_marker_o (clr_marker)
    );

    cfgw_frame_seq #(
        .T2 (T2), .T3 (T3), .T4 (T4), .T5 (T5),
        .T6 (T6), .T7 (T7), .T8 (T8), .T9 (T9)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .line_s_i (line_s),
        .match_i  (match),
        .drive_o  (line_drive_low_o),
        .busy_o   (busy),
        .commit_o (commit)
    );

    assign match        = (commit.word == cfg_word_o);
    assign fe_disable_o = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_word_o <= '1;
            done_o     <= 1'b0;
            off_cmd_o  <= 1'b0;
            marker_o   <= 1'b1;
        end else begin
            done_o    <= commit.strobe;
            off_cmd_o <= commit.strobe && commit.word[0];
            if (commit.strobe)
                cfg_word_o <= commit.word;
            if (rm_set_i)
                marker_o <= 1'b1;
            else if (clr_marker)
                marker_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker (
    input logic        clk,
    input logic        rst,
    input logic        rm_set_i,
    input logic        line_drive_low_o,
    input logic        fe_disable_o,
    input logic        marker_o,
    input logic [13:0] cfg_word_o,
    input logic        done_o,
    input logic        off_cmd_o
);
    assert_drive_in_xfer_R10: assert property (@(posedge clk) disable iff (rst)
        line_drive_low_o |-> fe_disable_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_cfg_changes_on_done_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_word_o != $past(cfg_word_o)) |-> done_o);

    assert_off_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        off_cmd_o |-> done_o);

    assert_marker_set_source_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(marker_o) |-> $past(rm_set_i));

    assert_marker_follows_set_R11: assert property (@(posedge clk) disable iff (rst)
        rm_set_i |=> marker_o);

    assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !fe_disable_o);
endmodule

bind cfgw_slave cfgw_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .rm_set_i         (rm_set_i),
    .line_drive_low_o (line_drive_low_o),
    .fe_disable_o     (fe_disable_o),
    .marker_o         (marker_o),
    .cfg_word_o       (cfg_word_o),
    .done_o           (done_o),
    .off_cmd_o        (off_cmd_o)
);

// File: tb/cfgw_slave_test.sv
module cfgw_slave_test;
    localparam int P_T1MIN = 4;
    localparam int P_SMAX  = 20;
    localparam int P_LMIN  = 40;
    localparam int P_T2    = 5;
    localparam int P_T3    = 3;
    localparam int P_T4    = 2;
    localparam int P_T5    = 8;
    localparam int P_T6    = 16;
    localparam int P_T7    = 4;
    localparam int P_T8    = 3;
    localparam int P_T9    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_low = 1'b0;
    logic        rm_set = 1'b0;
    logic        line;
    logic        drive_low;
    logic        fe_dis;
    logic        marker;
    logic [13:0] cfg;
    logic        done;
    logic        off_cmd;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [13:0] model_cfg = 14'h3FFF;

    always #2 clk = ~clk;

    assign line = !(host_low || drive_low);

    cfgw_slave #(
        .T1_MIN (P_T1MIN), .SHORT_MAX (P_SMAX), .LONG_MIN (P_LMIN),
        .T2 (P_T2), .T3 (P_T3), .T4 (P_T4), .T5 (P_T5),
        .T6 (P_T6), .T7 (P_T7), .T8 (P_T8), .T9 (P_T9),
        .SYNC_STG (2)
    ) uut (
        .clk              (clk),
        .rst              (rst),
        .line_i           (line),
        .rm_set_i         (rm_set),
        .line_drive_low_o (drive_low),
        .fe_disable_o     (fe_dis),
        .marker_o         (marker),
        .cfg_word_o       (cfg),
        .done_o           (done),
        .off_cmd_o        (off_cmd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Host pulls line low for plen cycles, then acts as bit source.
    task automatic run_xfer(input int plen, input logic [13:0] w,
                            input logic [13:0] glitch, input bit expect_go,
                            input string req);
        logic [13:0] expw;
        bit ack_exp;
        int rises = 0, curw = 0, ackw = 0, badw = 0;
        int wait_left = 0, on_left = 0, pend = 0;
        bit host_on = 0, pd = 0, saw_busy = 0, saw_done = 0, saw_off = 0;
        expw    = w | glitch;
        ack_exp = expect_go && (expw == model_cfg);
        @(negedge clk);
        host_low = 1'b1;
        repeat (plen) @(negedge clk);
        host_low = 1'b0;
        for (int n = 0; n < 600 && !saw_done; n++) begin
            @(negedge clk);
            if (host_on) begin
                on_left--;
                if (on_left == 0) begin
                    host_low = 1'b0;
                    host_on  = 0;
                end
            end
            if (wait_left > 0) begin
                wait_left--;
                if (wait_left == 0 && pend > 0) begin
                    host_low = 1'b1;
                    host_on  = 1;
                    on_left  = pend;
                end
            end
            if (drive_low && !pd) begin
                rises++;
                if (rises <= 14) begin
                    wait_left = P_T3 + P_T4;
                    pend = w[rises-1] ? 0 : (glitch[rises-1] ? 1 : P_T7);
                end
            end
            if (!drive_low && pd) begin
                if (rises <= 14) begin
                    if (curw != P_T3) badw++;
                end else begin
                    ackw = curw;
                end
                curw = 0;
            end
            if (drive_low) curw++;
            pd = drive_low;
            if (fe_dis) saw_busy = 1;
            if (done) begin
                saw_done = 1;
                saw_off  = off_cmd;
            end
        end
        if (expect_go) begin
            check(saw_busy, {req, " R10 busy during transfer"}, saw_busy, 1);
            check(saw_done, {req, " R8 done strobe"}, saw_done, 1);
            check(cfg == expw, {req, " R6 received word"}, cfg, expw);
            check(rises == 14 + (ack_exp ? 1 : 0), {req, " R5/R7 pulse count"},
                  rises, 14 + (ack_exp ? 1 : 0));
            check(badw == 0, {req, " R5 sync width"}, badw, 0);
            if (ack_exp)
                check(ackw == P_T8, {req, " R7 ack width"}, ackw, P_T8);
            check(saw_off == expw[0], {req, " R9 off command"}, saw_off, expw[0]);
            model_cfg = expw;
        end else begin
            check(!saw_busy, {req, " ignored pulse left idle"}, saw_busy, 0);
            check(cfg == model_cfg, {req, " ignored pulse kept word"}, cfg, model_cfg);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(drive_low == 0, "R1 drive released", drive_low, 0);
        check(fe_dis == 0, "R1 fe_disable low", fe_dis, 0);
        check(cfg == 14'h3FFF, "R1 cfg reset", cfg, 14'h3FFF);
        check(marker == 1, "R1 marker set", marker, 1);
        check(done == 0 && off_cmd == 0, "R1 strobes low", done, 0);

        // R2 short pulse refused while marker set
        run_xfer(10, 14'h0000, 14'h0, 0, "R2 short with marker");
        check(marker == 1, "R2 marker kept", marker, 1);
        // R3 one below long threshold refused
        run_xfer(P_LMIN - 1, 14'h0000, 14'h0, 0, "R4 long-1 with marker");
        // R3 long pulse starts and clears marker
        run_xfer(P_LMIN, 14'h1555, 14'h0, 1, "R3 long start");
        check(marker == 0, "R3 marker cleared", marker, 0);
        // R7 repeat same word gives acknowledge
        run_xfer(10, 14'h1555, 14'h0, 1, "R7 repeat");
        // R4 ignored lengths
        run_xfer(P_T1MIN - 1, 14'h0, 14'h0, 0, "R4 below min");
        run_xfer(P_SMAX + 1, 14'h0, 14'h0, 0, "R4 above short max");
        run_xfer(P_LMIN - 1, 14'h0, 14'h0, 0, "R4 below long min");
        // R2 short boundaries accepted with marker clear
        run_xfer(P_T1MIN, 14'h2AAA, 14'h0, 1, "R2 min length");
        run_xfer(P_SMAX, 14'h2AAA, 14'h0, 1, "R2 max length");
        // R6 sweep: walking zero, then its repeat for acknowledge
        for (int i = 0; i < 14; i++) begin
            run_xfer(8, 14'h3FFF & ~(14'h1 << i), 14'h0, 1, "R6 walking zero");
            run_xfer(8, 14'h3FFF & ~(14'h1 << i), 14'h0, 1, "R7 walking repeat");
        end
        run_xfer(8, 14'h0000, 14'h0, 1, "R6 all zero");
        run_xfer(8, 14'h3FFF, 14'h0, 1, "R6 all one");
        run_xfer(8, 14'h3FFE, 14'h0, 1, "R9 bit0 zero");
        // R6 short low (below half of T7) reads as 1
        run_xfer(8, 14'h0000, 14'h00F0, 1, "R6 short low");
        // R11 reset event sets marker, then short pulse refused
        @(negedge clk);
        rm_set = 1'b1;
        @(negedge clk);
        rm_set = 1'b0;
        check(marker == 1, "R11 marker set", marker, 1);
        run_xfer(10, 14'h0, 14'h0, 0, "R2 short after rm_set");
        run_xfer(P_LMIN + 5, 14'h0F0F, 14'h0, 1, "R3 long after rm_set");
        check(marker == 0, "R3 marker cleared again", marker, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule